// File: doc/BRIEF.md
# Floating-Point Precision Widening Converter

This block takes a binary floating-point operand in half (16-bit) or single (32-bit) format and rewrites it exactly in a wider format: half to single, half to double, or single to double. A two-bit conversion selector picks the pair of formats. The sign is carried over unchanged. The exponent is moved from the source bias to the target bias by adding a constant. The fraction is padded with zeros on its least significant end.

Special values keep their meaning in the wider format. Zeros stay signed zeros. Infinities stay infinities. NaNs keep their payload, left-aligned, and are not quieted. A subnormal source always lands in the normal range of the wider format. Its fraction is shifted left by a leading-zero count until the first set bit becomes the hidden bit, and the exponent is reduced by the same amount. Along with each result, the block reports one of five class flags for the input.

The conversion itself is combinational. The result, the flags and a valid strobe are captured in one output register stage.

Top module: `fp_widen_unit`

## Requirements
- R1: A conversion presented with `in_vld` high appears on `out_res` and the class flags one clock edge later, with `out_vld` high. When `in_vld` is low, `out_vld` goes low on the next edge and `out_res` and the flags keep their previous values.
- R2: `in_sel` encodes the conversion as follows. 0 is half to single: the source is `in_op[15:0]`, the result is in `out_res[31:0]` and `out_res[63:32]` is zero. 1 is half to double: the source is `in_op[15:0]`. 2 is single to double: the source is `in_op[31:0]`. 3 behaves exactly like 2. In the half modes, `in_op[31:16]` has no effect.
- R3: For a normal input (exponent field neither 0 nor all ones), the sign is copied. The exponent becomes the source exponent plus 112 (half to single), 1008 (half to double) or 896 (single to double). The source fraction fills the top of the target fraction, with zeros below it. No flag is set.
- R4: An input whose exponent and fraction fields are both zero gives a zero of the same sign and sets `out_zero`.
- R5: An input with an all-ones exponent and a zero fraction gives an infinity of the same sign (all-ones target exponent, zero fraction) and sets `out_inf`.
- R6: An input with an all-ones exponent and a nonzero fraction gives an all-ones target exponent, with the source fraction left-aligned and zero-padded. It sets `out_qnan` if the source fraction MSB is 1 and `out_snan` if it is 0. The fraction MSB is never changed.
- R7: A subnormal input (exponent zero, fraction nonzero) sets `out_sub` and is renormalized. With z leading zeros in the source fraction, the bits below its leading one are shifted to the top of the target fraction. The target exponent is (target bias − source bias − z), where the biases are 15, 127 and 1023.
- R8: At most one of the five class flags is set at any time.
- R9: While reset is asserted, `out_vld`, `out_res` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand valid |
| in_op | input | 32 | Source operand (half in bits 15:0) |
| in_sel | input | 2 | Conversion select, encoding per R2 |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_res | output | 64 | Widened result (single in bits 31:0) |
| out_zero | output | 1 | Input was a zero |
| out_inf | output | 1 | Input was an infinity |
| out_qnan | output | 1 | Input was a quiet NaN |
| out_snan | output | 1 | Input was a signaling NaN |
| out_sub | output | 1 | Input was subnormal |

## Verification
On every cycle, the assertions check the following:
- The valid strobe follows its input by one cycle.
- The class flags are mutually exclusive.
- A zero result has no bits set except the sign.
- Special values carry an all-ones exponent and quiet NaNs keep the fraction MSB.
- The single-format result leaves the upper word clear.
- The sign is carried through in the single-to-double mode.

Exact exponent rebiasing, the shift and exponent correction for every subnormal leading-zero count, the holding of results while idle, and the independence from the unused upper operand bits can only be shown by the bench. It compares each result with a reference conversion that steps the fraction one bit at a time.

// File: rtl/fp_widen_pkg.sv
package fp_widen_pkg;

    typedef enum logic [1:0] {
        SEL_H2S = 2'd0,
        SEL_H2D = 2'd1,
        SEL_S2D = 2'd2,
        SEL_ALT = 2'd3
    } cvt_sel_e;

    typedef struct packed {
        logic zero;
        logic inf;
        logic qnan;
        logic snan;
        logic sub;
    } fp_class_t;

    localparam int RES_W  = 64;
    localparam int OP_W   = 32;
    localparam int N_PATH = 3;

    // per-path format table: half->single, half->double, single->double
    localparam int SRC_EW [N_PATH] = '{5, 5, 8};
    localparam int SRC_FW [N_PATH] = '{10, 10, 23};
    localparam int DST_EW [N_PATH] = '{8, 11, 11};
    localparam int DST_FW [N_PATH] = '{23, 52, 52};

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
        fp_class_t        cls;
    } cvt_state_t;

endpackage

// File: rtl/fp_lzc.sv
module fp_lzc #(
    parameter int W  = 10,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fp_widen_path.sv
module fp_widen_path
    import fp_widen_pkg::*;
#(
    parameter int SEW = 5,
    parameter int SFW = 10,
    parameter int TEW = 8,
    parameter int TFW = 23,
    localparam int SW = 1 + SEW + SFW,
    localparam int DW = 1 + TEW + TFW
) (
    input  logic [SW-1:0] src,
    output logic [DW-1:0] dst,
    output fp_class_t     cls
);
    localparam int PAD   = TFW - SFW;
    localparam int LZW   = $clog2(SFW + 1);
    localparam int SBIAS = (1 << (SEW - 1)) - 1;
    localparam int TBIAS = (1 << (TEW - 1)) - 1;
    localparam int BDIFF = TBIAS - SBIAS;

    logic           sgn;
    logic [SEW-1:0] sexp;
    logic [SFW-1:0] sfrac;
    logic [LZW-1:0] lz;
    logic [SFW-1:0] nfrac;
    logic [TEW-1:0] texp;
    logic [SFW-1:0] ofrac;
    logic           exp_max, exp_min, frac_nz;

    assign sgn   = src[SW-1];
    assign sexp  = src[SFW +: SEW];
    assign sfrac = src[SFW-1:0];

    fp_lzc #(.W(SFW)) u_lzc (
        .vec (sfrac),
        .cnt (lz)
    );

    always_comb begin
        exp_max  = &sexp;
        exp_min  = ~|sexp;
        frac_nz  = |sfrac;
        cls      = '0;
        cls.zero = exp_min & ~frac_nz;
        cls.sub  = exp_min &  frac_nz;
        cls.inf  = exp_max & ~frac_nz;
        cls.qnan = exp_max &  frac_nz &  sfrac[SFW-1];
        cls.snan = exp_max &  frac_nz & ~sfrac[SFW-1];
        // drop the leading one: it becomes the hidden bit
        nfrac    = (sfrac << lz) << 1;
        if (exp_max) begin
            texp  = '1;
            ofrac = sfrac;
        end else if (exp_min) begin
            texp  = frac_nz ? (TEW'(BDIFF) - TEW'(lz)) : '0;
            ofrac = frac_nz ? nfrac : '0;
        end else begin
            texp  = TEW'(sexp) + TEW'(BDIFF);
            ofrac = sfrac;
        end
        dst = {sgn, texp, ofrac, {PAD{1'b0}}};
    end
endmodule

// File: rtl/fp_widen_unit.sv
module fp_widen_unit
    import fp_widen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [31:0] in_op,
    input  logic [1:0]  in_sel,
    output logic        out_vld,
    output logic [63:0] out_res,
    output logic        out_zero,
    output logic        out_inf,
    output logic        out_qnan,
    output logic        out_snan,
    output logic        out_sub
);
    logic [RES_W-1:0] path_res [N_PATH];
    fp_class_t        path_cls [N_PATH];

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        localparam int SW = 1 + SRC_EW[g] + SRC_FW[g];
        localparam int DW = 1 + DST_EW[g] + DST_FW[g];
        logic [DW-1:0] dst;
        fp_widen_path #(
            .SEW (SRC_EW[g]),
            .SFW (SRC_FW[g]),
            .TEW (DST_EW[g]),
            .TFW (DST_FW[g])
        ) u_path (
            .src (in_op[SW-1:0]),
            .dst (dst),
            .cls (path_cls[g])
        );
        assign path_res[g] = RES_W'(dst);
    end

    cvt_state_t st_d, st_q;
    logic [1:0] pick;

    always_comb begin
        case (cvt_sel_e'(in_sel))
            SEL_H2S: pick = 2'd0;
            SEL_H2D: pick = 2'd1;
            default: pick = 2'd2;
        endcase
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.res = path_res[pick];
            st_d.cls = path_cls[pick];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_res  = st_q.res;
    assign out_zero = st_q.cls.zero;
    assign out_inf  = st_q.cls.inf;
    assign out_qnan = st_q.cls.qnan;
    assign out_snan = st_q.cls.snan;
    assign out_sub  = st_q.cls.sub;
endmodule

// File: rtl/fp_widen_unit_chk.sv
module fp_widen_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [31:0] in_op,
    input logic [1:0]  in_sel,
    input logic        out_vld,
    input logic [63:0] out_res,
    input logic        out_zero,
    input logic        out_inf,
    input logic        out_qnan,
    input logic        out_snan,
    input logic        out_sub
);
    AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R1
    AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld); // R1
    AST_SINGLE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && $past(in_sel) == 2'd0 |-> out_res[63:32] == 32'd0); // R2
    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && in_sel == 2'd2 |=> out_res[63] == $past(in_op[31])); // R3
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && out_zero |-> $countones(out_res) <= 1); // R4
    AST_SPECIAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && (out_inf || out_qnan || out_snan) && $past(in_sel) != 2'd0
        |-> &out_res[62:52]); // R5
    AST_QNAN_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && out_qnan && $past(in_sel) != 2'd0 |-> out_res[51]); // R6
    AST_SUB_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && out_sub && $past(in_sel) != 2'd0
        |-> out_res[62:52] != 11'd0 && !(&out_res[62:52])); // R7
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_zero, out_inf, out_qnan, out_snan, out_sub})); // R8
endmodule

bind fp_widen_unit fp_widen_unit_chk u_chk (.*);

// File: tb/fp_widen_unit_tb.sv
module fp_widen_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_op = '0;
    logic [1:0]  in_sel = '0;
    logic        out_vld;
    logic [63:0] out_res;
    logic        out_zero, out_inf, out_qnan, out_snan, out_sub;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fp_widen_unit u_dut (.*);

    task automatic chk(input bit ok, input string req,
                       input logic [68:0] act, input logic [68:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns {zero,inf,qnan,snan,sub, res[63:0]}
    function automatic logic [68:0] ref_cvt(input logic [31:0] op, input logic [1:0] sel);
        int sew, sfw, sb, tew, tfw, tb, e, te;
        logic [63:0] m, r;
        logic [4:0]  fl;
        logic        s;
        if (sel == 2'd0) begin sew = 5; sfw = 10; sb = 15; tew = 8; tfw = 23; tb = 127; end
        else if (sel == 2'd1) begin sew = 5; sfw = 10; sb = 15; tew = 11; tfw = 52; tb = 1023; end
        else begin sew = 8; sfw = 23; sb = 127; tew = 11; tfw = 52; tb = 1023; end
        s  = op[sew + sfw];
        e  = int'((op >> sfw) & ((32'd1 << sew) - 1));
        m  = 64'(op & ((32'd1 << sfw) - 1));
        fl = '0;
        if (e == 0 && m == 0) begin
            fl = 5'b10000; te = 0;
        end else if (e == (1 << sew) - 1) begin
            te = (1 << tew) - 1;
            if (m == 0) fl = 5'b01000;
            else if (m[sfw-1]) fl = 5'b00100;
            else fl = 5'b00010;
        end else if (e == 0) begin
            fl = 5'b00001;
            te = 1 - sb + tb;
            while (m[sfw] == 1'b0) begin m = m << 1; te--; end
            m = m & ((64'd1 << sfw) - 1);
        end else begin
            te = e - sb + tb;
        end
        r = (64'(s) << (tew + tfw)) | (64'(te) << tfw) | (m << (tfw - sfw));
        return {fl, r};
    endfunction

    logic [63:0] last_res;
    logic [4:0]  last_fl;

    task automatic run(input logic [31:0] op, input logic [1:0] sel, input string req);
        logic [68:0] exp;
        logic [68:0] act;
        exp    = ref_cvt(op, sel);
        in_vld = 1'b1; in_op = op; in_sel = sel;
        @(negedge clk);
        act = {out_zero, out_inf, out_qnan, out_snan, out_sub, out_res};
        chk(out_vld === 1'b1, "R1 vld", 69'(out_vld), 69'd1);
        chk(act === exp, req, act, exp);
        last_res = out_res;
        last_fl  = act[68:64];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({out_vld, out_res, out_zero, out_inf, out_qnan, out_snan, out_sub} === '0,
            "R9 reset", 69'(out_res), 69'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_vld === 1'b0, "R9 idle", 69'(out_vld), 69'd0);

        run(32'h0000_0001, 2'd0, "R7 half min subnormal to single");
        run(32'h0000_03FF, 2'd1, "R7 half max subnormal to double");
        run(32'h0000_0200, 2'd0, "R7 half subnormal top bit");
        run(32'h0000_0001, 2'd2, "R7 single min subnormal");
        run(32'h0000_8000, 2'd1, "R4 negative zero");
        run(32'h0000_0000, 2'd2, "R4 positive zero");
        run(32'h0000_7C00, 2'd1, "R5 half infinity");
        run(32'h0000_FC00, 2'd0, "R5 half negative infinity");
        run(32'hFF80_0000, 2'd2, "R5 single negative infinity");
        run(32'h0000_7E01, 2'd1, "R6 half quiet NaN");
        run(32'h0000_7C01, 2'd0, "R6 half signaling NaN");
        run(32'h7F80_0001, 2'd3, "R6 single signaling NaN via sel3");
        run(32'hFFFF_3C00, 2'd0, "R2 upper bits ignored half to single");
        run(32'hA5A5_3C00, 2'd1, "R2 upper bits ignored half to double");
        run(32'h3F80_0000, 2'd2, "R3 single one");
        run(32'h0000_7BFF, 2'd1, "R3 half max normal");
        run(32'h0000_0400, 2'd0, "R3 half min normal");

        // hold while idle
        in_vld = 1'b0; in_op = 32'h1234_5678; in_sel = 2'd2;
        @(negedge clk);
        chk(out_vld === 1'b0, "R1 vld drop", 69'(out_vld), 69'd0);
        chk({out_zero, out_inf, out_qnan, out_snan, out_sub, out_res} === {last_fl, last_res},
            "R1 hold", {out_zero, out_inf, out_qnan, out_snan, out_sub, out_res},
            {last_fl, last_res});

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] op;
            logic [1:0]  sel;
            int k;
            sel = 2'($urandom % 4);
            op  = $urandom;
            k   = $urandom % 8;
            if (sel < 2) begin
                if (k == 0) op[14:10] = '0;
                if (k == 1) op[14:10] = '1;
                if (k == 2) op[14:0]  = '0;
                if (k == 3) begin op[14:10] = '0; op[9:0] = op[9:0] >> ($urandom % 10); end
            end else begin
                if (k == 0) op[30:23] = '0;
                if (k == 1) op[30:23] = '1;
                if (k == 2) op[30:0]  = '0;
                if (k == 3) begin op[30:23] = '0; op[22:0] = op[22:0] >> ($urandom % 23); end
            end
            run(op, sel, "R3 R8 random conversion");
            chk($countones({out_zero, out_inf, out_qnan, out_snan, out_sub}) <= 1,
                "R8 one class", 69'(last_fl), 69'd0);
            if ((i % 50) == 0) begin
                in_vld = 1'b0; in_op = $urandom;
                @(negedge clk);
                chk(out_res === last_res, "R1 hold random", 69'(out_res), 69'(last_res));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule